// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Driver

This block lights a row of seven-segment digits that share one set of segment lines. It enables one digit at a time and steps through the digits by time division. Each digit's 4-bit BCD code is turned into a segment pattern, and each digit has its own decimal-point bit. The segments, the decimal point and the digit enables are all registered. The slot given to each digit is derived from the clock frequency and a target refresh rate, so every digit is refreshed more than 100 times per second.

At the start of each slot all digit enables are switched off for a short blanking interval. The shared segment bus changes only inside that interval, which prevents ghosting between neighbouring digits. One parameter selects the display type, common-cathode or common-anode, and that choice sets the polarity of both the segment lines and the digit enables.

The driver is meant to sit in front of external digit drivers and resistors. It takes a packed BCD word and a decimal-point mask, and it shows them continuously with no further handshake.

Top module: `mux7_display`

## Requirements
- R1: At any clock cycle at most one digit enable is in its active state.
- R2: Digits are served in ascending index order, 0 to N_DIGITS-1, and the order wraps back to 0. Digit k takes its code from `bcd_i[4k+3:4k]`, its decimal-point bit from `dp_mask_i[k]` and its enable from `dig_en_o[k]`.
- R3: Each slot lasts SLOT_CYCLES = CLK_HZ/(REFRESH_HZ*N_DIGITS) cycles. During a slot the digit's enable is active for SLOT_CYCLES-BLANK_CYCLES consecutive cycles, and it is preceded by BLANK_CYCLES cycles with every enable inactive.
- R4: A given digit is enabled again every N_DIGITS*SLOT_CYCLES cycles. This period is at most CLK_HZ/100 cycles, so the refresh rate exceeds 100 Hz.
- R5: `seg_o` and `dp_o` change only between two consecutive cycles in which all digit enables are inactive.
- R6: While a digit is enabled, a code of 0 to 9 shows the standard pattern. `seg_o` bit 0 is segment a and bit 6 is segment g. In the lit sense (a 1 means lit) the patterns for codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hex.
- R7: While a digit is enabled, codes 10 to 15 leave all seven segments dark.
- R8: While a digit is enabled, `dp_o` is lit exactly when that digit's mask bit is 1.
- R9: With COMMON_ANODE=0, segments and the decimal point are lit by a high level and a digit enable is active low. With COMMON_ANODE=1 every one of these levels is inverted.
- R10: While `rst_n` is low, every enable is inactive and all segments and the decimal point are dark. After reset is released, digit 0 is the first digit enabled, and its enable becomes active on the (BLANK_CYCLES+1)-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bcd_i | input | 4*N_DIGITS | Packed BCD codes, digit k in bits 4k+3..4k |
| dp_mask_i | input | N_DIGITS | Decimal-point request, one bit per digit |
| seg_o | output | 7 | Shared segment lines a (bit 0) to g (bit 6) |
| dp_o | output | 1 | Shared decimal-point line |
| dig_en_o | output | N_DIGITS | Digit enables, one per digit |

## Verification
The first enable of digit 0 is due on the (BLANK_CYCLES+1)-th rising edge after reset is released. The bench counts edges from the release and samples at the following falling edge. Within a slot, the segment bus loads on the slot's second edge, and the enable follows BLANK_CYCLES-1 edges later. Because of this, a new input word is fully visible only after one complete frame. The bench therefore holds each input word for two frames before it compares anything. It then checks every falling edge of the next two frames against patterns it computes itself, measures the lengths of the enable and gap runs, and measures the spacing between successive digit-0 enables.

// File: rtl/disp_pkg.sv
// Package: shared types and helpers for the multiplexed display driver.
// Assumes segment patterns are held internally in the lit sense (1 = lit).
package disp_pkg;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_DARK = 7'h00;

    // Lit-sense pattern for a BCD code; codes above 9 give a dark digit.
    function automatic seg_t bcd_to_seg(input logic [3:0] code);
        seg_t p;
        case (code)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = SEG_DARK;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/seg_decoder.sv
// Module: seg_decoder
// Converts one 4-bit BCD code into a lit-sense segment pattern (bit 0 = a).
// Assumes codes 10..15 mean "blank"; purely combinational.
module seg_decoder
    import disp_pkg::*;
(
    input  logic [3:0] code_i,
    output seg_t       pat_o
);

    // Table lookup through the package function.
    always_comb begin
        pat_o = bcd_to_seg(code_i);
    end

endmodule

// File: rtl/scan_sequencer.sv
// Module: scan_sequencer
// Times the digit slots: a slot counter runs 0..SLOT_CYCLES-1 and the digit
// index advances when it wraps. It flags the segment-load cycle (count 1) and
// the display window (count >= BLANK_CYCLES).
// Assumes 2 <= BLANK_CYCLES < SLOT_CYCLES, so loading always falls in the blank.
module scan_sequencer #(
    parameter int N_DIGITS     = 4,
    parameter int SLOT_CYCLES  = 16,
    parameter int BLANK_CYCLES = 2,
    localparam int CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1,
    localparam int IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx_o,
    output logic             load_stb_o,
    output logic             show_o
);

    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_SHOW  = CNT_W'(BLANK_CYCLES);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_DIGITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             slot_end;

    // Detect the last cycle of a slot.
    always_comb begin
        slot_end = (cnt == CNT_LAST);
    end

    // Slot cycle counter, restarting at zero every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (slot_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Digit index, advancing in ascending order and wrapping to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (slot_end) begin
            idx <= (idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
        end
    end

    // Phase flags derived from the slot counter.
    always_comb begin
        idx_o      = idx;
        load_stb_o = (cnt == CNT_LOAD);
        show_o     = (cnt >= CNT_SHOW);
    end

endmodule

// File: rtl/seg_output_stage.sv
// Module: seg_output_stage
// Registers the shared segment bus, the decimal point and the one-hot digit
// enable in lit sense, then maps them onto the pin polarity of the display type.
// Assumes load_stb_i only pulses while show_i is low.
module seg_output_stage
    import disp_pkg::*;
#(
    parameter int N_DIGITS     = 4,
    parameter bit COMMON_ANODE = 1'b0,
    localparam int IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_stb_i,
    input  logic                show_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  seg_t                pat_i,
    input  logic                dp_i,
    output logic [6:0]          seg_o,
    output logic                dp_o,
    output logic [N_DIGITS-1:0] dig_en_o
);

    seg_t                seg_lit;
    logic                dp_lit;
    logic [N_DIGITS-1:0] en_lit;
    logic [N_DIGITS-1:0] en_next;

    // One-hot enable for the current digit while its window is open.
    always_comb begin
        en_next = '0;
        if (show_i) begin
            en_next = N_DIGITS'(1) << idx_i;
        end
    end

    // Segment and decimal-point register, loaded once per slot inside the blank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_lit <= SEG_DARK;
            dp_lit  <= 1'b0;
        end else if (load_stb_i) begin
            seg_lit <= pat_i;
            dp_lit  <= dp_i;
        end
    end

    // Digit-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_lit <= '0;
        end else begin
            en_lit <= en_next;
        end
    end

    // Pin polarity chosen by display type.
    generate
        if (COMMON_ANODE) begin : g_anode
            // Common anode: segments sink (low = lit), digit enable high.
            always_comb begin
                seg_o    = ~seg_lit;
                dp_o     = ~dp_lit;
                dig_en_o = en_lit;
            end
        end else begin : g_cathode
            // Common cathode: segments high = lit, digit enable low.
            always_comb begin
                seg_o    = seg_lit;
                dp_o     = dp_lit;
                dig_en_o = ~en_lit;
            end
        end
    endgenerate

endmodule

// File: rtl/mux7_display.sv
// Module: mux7_display (top)
// Time-multiplexed driver for N_DIGITS seven-segment digits on a shared
// segment bus. The slot length comes from CLK_HZ and REFRESH_HZ; every slot
// opens with BLANK_CYCLES of all-off enables before the digit is shown.
// Assumes CLK_HZ is high enough that a slot exceeds the blanking interval.
module mux7_display
    import disp_pkg::*;
#(
    parameter int N_DIGITS     = 4,
    parameter int CLK_HZ       = 50_000_000,
    parameter int REFRESH_HZ   = 200,
    parameter int BLANK_CYCLES = 500,
    parameter bit COMMON_ANODE = 1'b0,
    localparam int RATE_HZ     = (REFRESH_HZ > 100) ? REFRESH_HZ : 101,
    localparam int RAW_SLOT    = CLK_HZ / (RATE_HZ * N_DIGITS),
    localparam int BLANK_EFF   = (BLANK_CYCLES < 2) ? 2 : BLANK_CYCLES,
    localparam int SLOT_CYCLES = (RAW_SLOT > BLANK_EFF) ? RAW_SLOT : BLANK_EFF + 1,
    localparam int IDX_W       = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [4*N_DIGITS-1:0] bcd_i,
    input  logic [N_DIGITS-1:0]   dp_mask_i,
    output logic [6:0]            seg_o,
    output logic                  dp_o,
    output logic [N_DIGITS-1:0]   dig_en_o
);

    logic [IDX_W-1:0] idx;
    logic             load_stb;
    logic             show;
    seg_t             pats [N_DIGITS];
    seg_t             pat_sel;
    logic             dp_sel;

    scan_sequencer #(
        .N_DIGITS    (N_DIGITS),
        .SLOT_CYCLES (SLOT_CYCLES),
        .BLANK_CYCLES(BLANK_EFF)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_o     (idx),
        .load_stb_o(load_stb),
        .show_o    (show)
    );

    // One decoder per digit, each on its own nibble of the packed input.
    generate
        for (genvar k = 0; k < N_DIGITS; k++) begin : g_dec
            seg_decoder u_dec (
                .code_i(bcd_i[4*k +: 4]),
                .pat_o (pats[k])
            );
        end
    endgenerate

    // Select the pattern and decimal-point bit of the digit being served.
    always_comb begin
        pat_sel = SEG_DARK;
        dp_sel  = 1'b0;
        for (int k = 0; k < N_DIGITS; k++) begin
            if (idx == IDX_W'(k)) begin
                pat_sel = pats[k];
                dp_sel  = dp_mask_i[k];
            end
        end
    end

    seg_output_stage #(
        .N_DIGITS    (N_DIGITS),
        .COMMON_ANODE(COMMON_ANODE)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb_i(load_stb),
        .show_i    (show),
        .idx_i     (idx),
        .pat_i     (pat_sel),
        .dp_i      (dp_sel),
        .seg_o     (seg_o),
        .dp_o      (dp_o),
        .dig_en_o  (dig_en_o)
    );

endmodule

// File: rtl/mux7_display_chk.sv
// Module: mux7_display_chk
// Property checker for mux7_display, attached by bind. It translates pin
// polarity back to lit sense and checks the display protocol at the ports.
module mux7_display_chk #(
    parameter int N_DIGITS     = 4,
    parameter bit COMMON_ANODE = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [6:0]          seg_o,
    input logic                dp_o,
    input logic [N_DIGITS-1:0] dig_en_o,
    input logic                load_stb
);

    logic [N_DIGITS-1:0] act;
    logic [7:0]          lit;
    logic                seen;

    // Lit-sense view of the pins.
    always_comb begin
        act = COMMON_ANODE ? dig_en_o : ~dig_en_o;
        lit = COMMON_ANODE ? ~{dp_o, seg_o} : {dp_o, seg_o};
    end

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) begin
        seen <= 1'b1;
    end

    assert_one_digit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

    assert_load_in_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (act == '0));

    assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({dp_o, seg_o}) |-> (act == '0 && $past(act) == '0));

    assert_reset_dark_R10: assert property (@(posedge clk) disable iff (seen !== 1'b1)
        $past(!rst_n) |-> (act == '0 && lit == 8'h00));

endmodule

bind mux7_display mux7_display_chk #(
    .N_DIGITS    (N_DIGITS),
    .COMMON_ANODE(COMMON_ANODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .seg_o   (seg_o),
    .dp_o    (dp_o),
    .dig_en_o(dig_en_o),
    .load_stb(load_stb)
);

// File: tb/tb_mux7_display.sv
module tb_mux7_display;

    localparam int N      = 4;
    localparam int CLK_HZ = 24000;
    localparam int REF_HZ = 500;
    localparam int BLANK  = 3;
    localparam int SLOT   = CLK_HZ / (REF_HZ * N);
    localparam int FRAME  = N * SLOT;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4*N-1:0] bcd = '0;
    logic [N-1:0]   dpm = '0;
    logic [6:0]     seg_cc, seg_ca;
    logic           dp_cc, dp_ca;
    logic [N-1:0]   en_cc, en_ca;

    int n_checks = 0;
    int n_fail   = 0;
    int err [1:10];
    int f_act [1:10];
    int f_exp [1:10];

    always #2 clk = ~clk;

    mux7_display #(.N_DIGITS(N), .CLK_HZ(CLK_HZ), .REFRESH_HZ(REF_HZ),
                   .BLANK_CYCLES(BLANK), .COMMON_ANODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bcd_i(bcd), .dp_mask_i(dpm),
        .seg_o(seg_cc), .dp_o(dp_cc), .dig_en_o(en_cc));

    mux7_display #(.N_DIGITS(N), .CLK_HZ(CLK_HZ), .REFRESH_HZ(REF_HZ),
                   .BLANK_CYCLES(BLANK), .COMMON_ANODE(1'b1)) dut_ca (
        .clk(clk), .rst_n(rst_n), .bcd_i(bcd), .dp_mask_i(dpm),
        .seg_o(seg_ca), .dp_o(dp_ca), .dig_en_o(en_ca));

    function automatic logic [6:0] exp_pat(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic note(input int r, input int act, input int exp);
        if (err[r] == 0) begin
            f_act[r] = act;
            f_exp[r] = exp;
        end
        err[r]++;
    endtask

    // Observe 'cycles' falling edges with the inputs held, then report per requirement.
    task automatic observe(input int cycles);
        logic [N-1:0] pact = '0;
        logic [7:0]   pbus = '0;
        bit have_rise = 0, have_fall = 0, have_k = 0, have_t0 = 0;
        int on_len = 0, gap_len = 0, last_k = 0, t0 = 0;
        for (int r = 1; r <= 10; r++) err[r] = 0;
        for (int c = 0; c < cycles; c++) begin
            logic [N-1:0] act;
            logic [7:0]   bus;
            int           k;
            @(negedge clk);
            act = ~en_cc;
            bus = {dp_cc, seg_cc};
            k = -1;
            for (int i = 0; i < N; i++) if (act[i]) k = i;
            if ($countones(act) > 1) note(1, act, 0);
            if (en_ca != ~en_cc || seg_ca != ~seg_cc || dp_ca != ~dp_cc)
                note(9, {en_ca, dp_ca, seg_ca}, {~en_cc, ~dp_cc, ~seg_cc});
            if (k >= 0) begin
                logic [3:0] v;
                v = bcd[4*k +: 4];
                if (v < 10) begin
                    if (seg_cc != exp_pat(v)) note(6, seg_cc, exp_pat(v));
                end else if (seg_cc != 7'h00) begin
                    note(7, seg_cc, 0);
                end
                if (dp_cc != dpm[k]) note(8, dp_cc, dpm[k]);
            end
            if (c > 0) begin
                if (bus != pbus && (act != '0 || pact != '0)) note(5, bus, pbus);
                if (pact == '0 && act != '0) begin
                    if (have_fall && gap_len != BLANK) note(3, gap_len, BLANK);
                    if (have_k && k != (last_k + 1) % N) note(2, k, (last_k + 1) % N);
                    if (k == 0) begin
                        if (have_t0 && c - t0 != FRAME) note(4, c - t0, FRAME);
                        have_t0 = 1;
                        t0 = c;
                    end
                    have_k = 1;
                    last_k = k;
                    have_rise = 1;
                    on_len = 1;
                end else if (pact != '0 && act == '0) begin
                    if (have_rise && on_len != SLOT - BLANK) note(3, on_len, SLOT - BLANK);
                    have_fall = 1;
                    gap_len = 1;
                end else if (act != '0) begin
                    on_len++;
                end else begin
                    gap_len++;
                end
            end
            pact = act;
            pbus = bus;
        end
        check("R1 one digit",     err[1] == 0, f_act[1], f_exp[1]);
        check("R2 scan order",    err[2] == 0 && have_k, f_act[2], f_exp[2]);
        check("R3 slot timing",   err[3] == 0, f_act[3], f_exp[3]);
        check("R4 refresh",       err[4] == 0 && have_t0, f_act[4], f_exp[4]);
        check("R5 bus quiet",     err[5] == 0, f_act[5], f_exp[5]);
        check("R6 decode 0..9",   err[6] == 0, f_act[6], f_exp[6]);
        check("R7 blank codes",   err[7] == 0, f_act[7], f_exp[7]);
        check("R8 decimal point", err[8] == 0, f_act[8], f_exp[8]);
        check("R9 polarity",      err[9] == 0, f_act[9], f_exp[9]);
    endtask

    task automatic apply(input logic [4*N-1:0] b, input logic [N-1:0] d);
        @(negedge clk);
        bcd = b;
        dpm = d;
        repeat (2 * FRAME) @(negedge clk);
        observe(2 * FRAME + 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: dark and disabled in reset, both polarities
        check("R10 reset cc", en_cc == '1 && seg_cc == 7'h00 && dp_cc == 1'b0,
              {en_cc, dp_cc, seg_cc}, {4'hF, 8'h00});
        check("R10 reset ca", en_ca == '0 && seg_ca == 7'h7F && dp_ca == 1'b1,
              {en_ca, dp_ca, seg_ca}, {4'h0, 8'hFF});
        rst_n = 1'b1;
        repeat (BLANK) @(posedge clk);
        @(negedge clk);
        check("R10 still blank", en_cc == '1, en_cc, 4'hF);
        @(posedge clk);
        @(negedge clk);
        check("R10 digit 0 first", en_cc == 4'b1110, en_cc, 4'b1110);
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        bcd = 16'h4321;
        dpm = 4'b0000;
        check("R4 frame within 100Hz", FRAME * 100 <= CLK_HZ, FRAME, CLK_HZ / 100);
        do_reset();
        apply(16'h3210, 4'b0001);
        apply(16'h7654, 4'b1010);
        apply(16'h1098, 4'b0101);
        apply(16'h8888, 4'b1111);
        apply(16'hFEDC, 4'b0000);   // R7 all blank codes
        apply(16'hBA9A, 4'b1001);   // R7 mixed with R6
        for (int i = 0; i < 30; i++) apply(16'($urandom), 4'($urandom));
        bcd = 16'h5A05;
        do_reset();                 // R10 mid-run reset restarts at digit 0
        for (int i = 0; i < 10; i++) apply(16'($urandom), 4'($urandom));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule